// File: doc/BRIEF.md
# Parallel register bus master

This block lets synchronous user logic reach the register file of an external peripheral that has an asynchronous, RAM-like parallel port: an address bus, a bidirectional data bus, and active-low write and read strobes. User logic hands over one request at a time. A request carries an address, a direction flag and, for writes, a data word. The block then runs the bus cycle. Read data comes back on a response port as a one-cycle valid pulse.

The block runs on a clock at twice the system rate. Every bus output comes straight from a flip-flop, so no strobe edge is ever formed by logic that combines an enable with the clock. The length of each phase of a bus cycle is a parameter counted in fast cycles. A write is one strobe-low phase followed by one strobe-high phase. At the default settings that gives one write per system clock. A read holds its strobe low long enough to cover the peripheral's access time. It keeps the address after the strobe rises, and it releases the data bus for the whole read plus one extra cycle.

The request port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, user logic must hold the request steady, and the request has no effect on the bus. The response port has no back-pressure: `rsp_data` is valid only in the single cycle where `rsp_valid` is high, and the consumer must take it then.

Top module: `pbm_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both strobes are high (inactive), the output enable `bus_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A write drives `bus_addr` and `bus_dout` and raises `bus_oe`, then holds `bus_wr_n` low for exactly WR_LOW cycles. Address and data stay unchanged up to and including the cycle in which the strobe rises, so the peripheral latches the requested word at the requested address on that rising edge.
- R3: Before the next fall, `bus_wr_n` stays high for at least WR_HIGH cycles. When writes are presented back to back, `req_ready` is high in the last high cycle, so one write is accepted every WR_LOW+WR_HIGH cycles.
- R4: A read holds `bus_rd_n` low for exactly RD_LOW cycles. `bus_din` is sampled at the clock edge that ends the last low cycle. `rsp_valid` is high for exactly one cycle, the first cycle in which `bus_rd_n` is high again, and `rsp_data` then carries the sampled word.
- R5: `bus_addr` and `bus_dout` change only at an edge where both strobes were high in the previous cycle. After a read, `bus_addr` is held for at least RD_HOLD+1 cycles after `bus_rd_n` rises.
- R6: `bus_oe` is low while `bus_rd_n` is low and for at least RD_HOLD+1 cycles after `bus_rd_n` rises. It is high only during the phases of a write.
- R7: Only one request is in flight at a time. `req_ready` is low while either strobe is low. A request held while `req_ready` is low starts no bus activity until it is accepted.
- R8: `bus_wr_n` and `bus_rd_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data is valid |
| rsp_data | output | DATA_W | Read data |
| bus_addr | output | ADDR_W | Address to the peripheral |
| bus_dout | output | DATA_W | Data driven toward the peripheral |
| bus_oe | output | 1 | 1 = master drives the data bus |
| bus_din | input | DATA_W | Data returned by the peripheral |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |

## Verification
The assertions check the following on every cycle:
- the exact low widths of both strobes and the minimum high width of the write strobe;
- that the strobes never overlap and that `req_ready` is low while a strobe is low;
- that address and data move only while both strobes are high;
- that the data bus stays released during the read and the hold window that follows it;
- that the response pulse lines up with the rising edge of the read strobe.

Only the bench scenarios can show the rest, because they need a model of the peripheral:
- that the right word lands at the right address;
- that read data is captured in the one cycle where the modelled peripheral presents it;
- that back-to-back writes keep the two-cycle rate;
- that a write held during a read waits out the full turnaround before it drives the bus.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WLO   = 3'd1,
    ST_WHI   = 3'd2,
    ST_RLO   = 3'd3,
    ST_RHOLD = 3'd4,
    ST_RTURN = 3'd5
  } pbm_state_t;

  function automatic int pbm_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pbm_phase_timer.sv
module pbm_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/pbm_sequencer.sv
module pbm_sequencer
  import pbm_pkg::*;
#(
  parameter int CW      = 2,
  parameter int WR_LOW  = 1,
  parameter int WR_HIGH = 1,
  parameter int RD_LOW  = 2,
  parameter int RD_HOLD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          t_done,
  output logic          req_ready,
  output logic          accept,
  output logic          t_load,
  output logic [CW-1:0] t_val,
  output logic          cap,
  output logic          wr_n,
  output logic          rd_n,
  output logic          oe
);

  localparam logic [CW-1:0] WL_V = CW'(WR_LOW - 1);
  localparam logic [CW-1:0] WH_V = CW'(WR_HIGH - 1);
  localparam logic [CW-1:0] RL_V = CW'(RD_LOW - 1);
  localparam logic [CW-1:0] RH_V = CW'(RD_HOLD - 1);

  pbm_state_t state, nxt;

  assign req_ready = (state == ST_IDLE) || (state == ST_RTURN) ||
                     ((state == ST_WHI) && t_done);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    cap    = 1'b0;
    case (state)
      ST_IDLE, ST_RTURN: nxt = ST_IDLE;
      ST_WLO: if (t_done) begin
        nxt    = ST_WHI;
        t_load = 1'b1;
        t_val  = WH_V;
      end
      ST_WHI: if (t_done) nxt = ST_IDLE;
      ST_RLO: if (t_done) begin
        nxt    = ST_RHOLD;
        t_load = 1'b1;
        t_val  = RH_V;
        cap    = 1'b1;
      end
      ST_RHOLD: if (t_done) nxt = ST_RTURN;
      default: nxt = ST_IDLE;
    endcase
    if (accept) begin
      nxt    = req_write ? ST_WLO : ST_RLO;
      t_load = 1'b1;
      t_val  = req_write ? WL_V : RL_V;
    end
  end

  // Strobes are registered from the next state: every bus edge is a flop edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wr_n  <= 1'b1;
      rd_n  <= 1'b1;
      oe    <= 1'b0;
    end else begin
      state <= nxt;
      wr_n  <= (nxt != ST_WLO);
      rd_n  <= (nxt != ST_RLO);
      oe    <= (nxt == ST_WLO) || (nxt == ST_WHI);
    end
  end

endmodule

// File: rtl/pbm_bus_regs.sv
module pbm_bus_regs #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_dout <= '0;
    end else if (accept) begin
      bus_addr <= req_addr;
      if (req_write) bus_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap;
      if (cap) rsp_data <= bus_din;
    end
  end

endmodule

// File: rtl/pbm_master.sv
module pbm_master
  import pbm_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int WR_LOW  = 1,
  parameter int WR_HIGH = 1,
  parameter int RD_LOW  = 2,
  parameter int RD_HOLD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_wr_n,
  output logic              bus_rd_n
);

  localparam int MAXPH = pbm_max4(WR_LOW, WR_HIGH, RD_LOW, RD_HOLD);
  localparam int CW    = $clog2(MAXPH + 1);

  logic          accept, t_load, t_done, cap;
  logic [CW-1:0] t_val;

  pbm_phase_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  pbm_sequencer #(
    .CW(CW), .WR_LOW(WR_LOW), .WR_HIGH(WR_HIGH), .RD_LOW(RD_LOW), .RD_HOLD(RD_HOLD)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .t_done(t_done), .req_ready(req_ready), .accept(accept), .t_load(t_load),
    .t_val(t_val), .cap(cap), .wr_n(bus_wr_n), .rd_n(bus_rd_n), .oe(bus_oe)
  );

  pbm_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cap(cap), .bus_din(bus_din),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

endmodule

// File: rtl/pbm_master_chk.sv
module pbm_master_chk #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int WR_LOW  = 1,
  parameter int WR_HIGH = 1,
  parameter int RD_LOW  = 2,
  parameter int RD_HOLD = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe,
  input logic              bus_wr_n,
  input logic              bus_rd_n
);

  localparam logic [15:0] WL   = 16'(WR_LOW);
  localparam logic [15:0] WH   = 16'(WR_HIGH);
  localparam logic [15:0] RL   = 16'(RD_LOW);
  localparam logic [15:0] RSAT = 16'(RD_HOLD + 1);

  logic [15:0] wr_lo, wr_hi, rd_lo, rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_lo <= '0;
      wr_hi <= WH;
      rd_lo <= '0;
      rd_hi <= RSAT;
    end else begin
      wr_lo <= bus_wr_n ? 16'd0 : wr_lo + 16'd1;
      rd_lo <= bus_rd_n ? 16'd0 : rd_lo + 16'd1;
      if (!bus_wr_n) wr_hi <= '0;
      else if (wr_hi < WH) wr_hi <= wr_hi + 16'd1;
      if (!bus_rd_n) rd_hi <= '0;
      else if (rd_hi < RSAT) rd_hi <= rd_hi + 16'd1;
    end
  end

  assert_wr_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> wr_lo == WL);

  assert_wr_latch_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> bus_oe && $stable(bus_dout) && $stable(bus_addr));

  assert_wr_high_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> wr_hi >= WH);

  assert_rd_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> rd_lo == RL);

  assert_rsp_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> rsp_valid);

  assert_rsp_only_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(bus_rd_n));

  assert_addr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bus_addr) || !$stable(bus_dout)) |->
      ($past(bus_wr_n) && $past(bus_rd_n) && rd_hi >= RSAT));

  assert_oe_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_rd_n && rd_hi >= RSAT));

  assert_busy_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || !bus_rd_n) |-> !req_ready);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_n || bus_rd_n);

endmodule

bind pbm_master pbm_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LOW(WR_LOW), .WR_HIGH(WR_HIGH),
  .RD_LOW(RD_LOW), .RD_HOLD(RD_HOLD)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
  .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
);

// File: tb/test_pbm_master.sv
`timescale 1ns/1ps
module test_pbm_master;

  localparam int AW      = 6;
  localparam int DW      = 8;
  localparam int WR_LOW  = 1;
  localparam int WR_HIGH = 1;
  localparam int RD_LOW  = 2;
  localparam int RD_HOLD = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic          bus_oe;
  logic [DW-1:0] bus_din;
  logic          bus_wr_n, bus_rd_n;

  pbm_master #(
    .ADDR_W(AW), .DATA_W(DW), .WR_LOW(WR_LOW), .WR_HIGH(WR_HIGH),
    .RD_LOW(RD_LOW), .RD_HOLD(RD_HOLD)
  ) i_pbm_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // Peripheral model: register file, latched on the rising write strobe,
  // read data valid only during the last low cycle of the read strobe.
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int lowcnt = 0;

  always @(posedge bus_wr_n) if (rst_n === 1'b1) mem[bus_addr] <= bus_dout;

  always @(posedge clk) lowcnt <= bus_rd_n ? 0 : lowcnt + 1;

  assign bus_din = (!bus_rd_n && lowcnt == RD_LOW - 1) ? mem[bus_addr] : DW'('hEE);

  // Port monitors.
  int wcnt = 0, last_wlow = 0, rcnt = 0, last_rlow = 0;
  int ogap = 0, last_ogap = -1, agap = 0, last_agap = -1;
  logic oe_d = 1'b0;
  logic [AW-1:0] a_d = '0;
  bit both_low = 0;
  logic [DW-1:0] last_rsp = '0;
  int nrsp = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n === 1'b1) begin
      if (!bus_wr_n) wcnt <= wcnt + 1;
      else begin
        if (wcnt != 0) last_wlow <= wcnt;
        wcnt <= 0;
      end
      if (!bus_rd_n) rcnt <= rcnt + 1;
      else begin
        if (rcnt != 0) last_rlow <= rcnt;
        rcnt <= 0;
      end
      if (!bus_rd_n) ogap <= 0;
      else if (!bus_oe) ogap <= ogap + 1;
      if (bus_oe && !oe_d) last_ogap <= ogap;
      oe_d <= bus_oe;
      if (!bus_rd_n) agap <= 0;
      else agap <= agap + 1;
      if (bus_addr != a_d) last_agap <= agap;
      a_d <= bus_addr;
      if (!bus_wr_n && !bus_rd_n) both_low <= 1;
      if (rsp_valid) begin
        last_rsp <= rsp_data;
        nrsp <= nrsp + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int acc);
    bit got;
    got = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!got) begin
      if (req_ready) begin
        got = 1;
        acc = cyc + 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 wr_n in reset", int'(bus_wr_n), 1);
    chk("R1 rd_n in reset", int'(bus_rd_n), 1);
    chk("R1 oe in reset", int'(bus_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_single_write();
    int acc;
    issue(1'b1, 6'd5, 8'h3C, acc);
    idle();
    repeat (4) @(negedge clk);
    chk("R2 write landed", int'(mem[5]), 'h3C);
    chk("R2 write strobe low width", last_wlow, WR_LOW);
  endtask

  task automatic t_burst_writes();
    int acc [4];
    for (int i = 0; i < 4; i++) issue(1'b1, AW'(16 + i), DW'('hA0 + i), acc[i]);
    idle();
    repeat (4) @(negedge clk);
    for (int i = 1; i < 4; i++)
      chk("R3 back-to-back accept spacing", acc[i] - acc[i-1], WR_LOW + WR_HIGH);
    for (int i = 0; i < 4; i++)
      chk("R3 burst write landed", int'(mem[16 + i]), 'hA0 + i);
  endtask

  task automatic t_read();
    int acc;
    issue(1'b0, 6'd17, '0, acc);
    idle();
    chk("R7 ready low during read", int'(req_ready), 0);
    repeat (RD_LOW - 1) @(negedge clk);
    chk("R4 rsp_valid not early", int'(rsp_valid), 0);
    @(negedge clk);
    chk("R4 rsp_valid pulse", int'(rsp_valid), 1);
    chk("R4 rsp_data value", int'(rsp_data), 'hA1);
    @(negedge clk);
    chk("R4 rsp_valid one cycle", int'(rsp_valid), 0);
    chk("R4 read strobe low width", last_rlow, RD_LOW);
  endtask

  task automatic t_read_then_held_write();
    int acc, n0;
    n0 = nrsp;
    issue(1'b0, 6'd18, '0, acc);
    issue(1'b1, 6'd40, 8'h5A, acc);   // held while busy
    idle();
    repeat (4) @(negedge clk);
    chk("R4 read before held write", int'(last_rsp), 'hA2);
    chk("R4 single response", nrsp - n0, 1);
    chk("R7 held write landed once done", int'(mem[40]), 'h5A);
    chk("R6 oe released after read strobe", last_ogap, RD_HOLD + 1);
    chk("R5 address hold after read", last_agap, RD_HOLD + 1);
  endtask

  task automatic t_write_then_read();
    int acc;
    issue(1'b1, 6'd33, 8'h77, acc);
    issue(1'b0, 6'd33, '0, acc);
    idle();
    repeat (RD_LOW + 3) @(negedge clk);
    chk("R4 read returns written word", int'(last_rsp), 'h77);
    chk("R8 strobes never overlap", int'(both_low), 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 3);
    t_reset();
    t_single_write();
    t_burst_writes();
    t_read();
    t_read_then_held_write();
    t_write_then_read();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule